// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block is the hazard control for a five-stage integer pipeline with fetch, decode, execute, memory and writeback stages. Branches and jumps are decided in decode, so a taken branch or jump discards only the one instruction behind it in fetch. The cost of deciding early is that a compare or a register-based jump in decode needs its operands sooner than an ordinary instruction does, so the unit adds stall rules for those consumers on top of the usual load-use rule.

The unit is purely combinational. Each cycle it looks at the source register indices of the decode-stage instruction and whether each one is actually read. It also looks at whether that instruction is a conditional branch, a direct jump (which reads no register) or a register-based jump. For the instructions in execute and memory it sees the destination index and two flags: whether the instruction writes a register and whether it is a load. A separate input carries the redirect decision made in decode. The outputs go straight to the enables and clears of the PC and the pipeline registers: hold the PC, hold the fetch/decode register, clear the fetch/decode register, and clear the decode/execute register so that a bubble enters execute.

No data flows through this block, so it has no valid/ready stream interface. Every pin is a plain control level that the pipeline samples at its next clock edge.

Top module: `hazard_unit`

## Requirements
- R1: When the execute-stage instruction is a load (write flag and load flag both 1) and its nonzero destination equals a used source of the decode-stage instruction, the unit stalls. Stalling means pc_stall, ifid_stall and idex_flush are all 1. This applies to any kind of decode-stage instruction.
- R2: A destination index of zero never causes a stall, whatever the flags of the producer say.
- R3: A source whose used flag is 0 never causes a stall. A producer whose write flag is 0 never causes a stall. A direct jump (id_is_jal = 1) is treated as reading no register.
- R4: A conditional branch or register-based jump in decode stalls when a used source matches the nonzero destination of a writing, non-load instruction in execute.
- R5: A conditional branch or register-based jump in decode stalls when a used source matches the nonzero destination of a load in memory. Together with R1, a load feeding such an instruction directly stalls it for two cycles.
- R6: No stall occurs for a non-load producer in memory. No stall occurs for a non-load producer in execute when the decode-stage instruction is neither a conditional branch nor a register-based jump.
- R7: pc_stall, ifid_stall and idex_flush are always equal, so a bubble enters execute whenever the PC and the fetch/decode register hold.
- R8: When id_redirect is 1 and there is no stall, ifid_flush is 1. ifid_flush is 0 whenever id_redirect is 0.
- R9: A stall takes priority over a redirect: when both are present, ifid_flush is 0 and the stall outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | IDX_W | First source register index of the decode-stage instruction |
| id_rs2 | input | IDX_W | Second source register index of the decode-stage instruction |
| id_rs1_used | input | 1 | The decode-stage instruction reads its first source |
| id_rs2_used | input | 1 | The decode-stage instruction reads its second source |
| id_is_branch | input | 1 | The decode-stage instruction is a conditional branch |
| id_is_jal | input | 1 | The decode-stage instruction is a direct jump |
| id_is_jalr | input | 1 | The decode-stage instruction is a register-based jump |
| id_redirect | input | 1 | Decode decided a taken branch or a jump this cycle |
| ex_rd | input | IDX_W | Destination index of the execute-stage instruction |
| ex_reg_write | input | 1 | The execute-stage instruction writes a register |
| ex_mem_read | input | 1 | The execute-stage instruction is a load |
| mem_rd | input | IDX_W | Destination index of the memory-stage instruction |
| mem_reg_write | input | 1 | The memory-stage instruction writes a register |
| mem_mem_read | input | 1 | The memory-stage instruction is a load |
| pc_stall | output | 1 | Hold the program counter |
| ifid_stall | output | 1 | Hold the fetch/decode pipeline register |
| ifid_flush | output | 1 | Clear the fetch/decode pipeline register |
| idex_flush | output | 1 | Clear the decode/execute pipeline register (insert a bubble) |

## Verification
The bound checker tests the output relations on every evaluation. The three stall outputs must agree, and a redirect must never flush under a stall. A load-use match must always stall, a zero destination pair must never stall, and a plain instruction must never stall unless a load sits in execute. What only the bench can show is the full classification across every combination of indices, flags and instruction kinds in a two-bit index configuration. That sweep includes the split between producers that do and do not stall a decode-stage compare. A directed pair of frames follows a load feeding a branch through both of its stall cycles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Producer stage positions in the per-stage hit vector
  localparam int unsigned PROD_EX  = 0;
  localparam int unsigned PROD_MEM = 1;
  localparam int unsigned NUM_PROD = 2;
  // Number of register sources an instruction may read
  localparam int unsigned NUM_SRC  = 2;

  typedef struct packed {
    logic wr;  // writes a register
    logic ld;  // value comes from memory
  } prod_kind_t;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src,
  input  logic             src_used,
  input  logic [IDX_W-1:0] dst,
  input  logic             dst_wr,
  output logic             hit
);
  // Register zero is hardwired, so it never carries a dependency.
  logic dst_live;
  assign dst_live = dst_wr && (dst != '0);
  assign hit      = src_used && dst_live && (src == dst);
endmodule

// File: rtl/hzd_cause.sv
module hzd_cause (
  input  logic hit_ex,
  input  logic hit_mem,
  input  logic ex_ld,
  input  logic mem_ld,
  input  logic ctl_reader,
  output logic stall
);
  logic load_use;
  logic ctl_on_ex_alu;
  logic ctl_on_mem_load;

  always_comb begin
    // Any consumer: loaded data exists only after memory.
    load_use        = hit_ex & ex_ld;
    // Decode-stage compare needs the value now; ALU result still in execute.
    ctl_on_ex_alu   = ctl_reader & hit_ex & ~ex_ld;
    // Decode-stage compare behind a load that is only now in memory.
    ctl_on_mem_load = ctl_reader & hit_mem & mem_ld;
    stall           = load_use | ctl_on_ex_alu | ctl_on_mem_load;
  end
endmodule

// File: rtl/hzd_flush_ctl.sv
module hzd_flush_ctl (
  input  logic stall,
  input  logic redirect,
  output logic pc_hold,
  output logic ifid_hold,
  output logic ifid_clear,
  output logic idex_clear
);
  always_comb begin
    pc_hold    = stall;
    ifid_hold  = stall;
    idex_clear = stall;
    // The compare is re-run once operands are valid, so a stall wins.
    ifid_clear = redirect & ~stall;
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hzd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic             id_rs1_used,
  input  logic             id_rs2_used,
  input  logic             id_is_branch,
  input  logic             id_is_jal,
  input  logic             id_is_jalr,
  input  logic             id_redirect,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_reg_write,
  input  logic             ex_mem_read,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_reg_write,
  input  logic             mem_mem_read,
  output logic             pc_stall,
  output logic             ifid_stall,
  output logic             ifid_flush,
  output logic             idex_flush
);
  logic [IDX_W-1:0] src_idx  [NUM_SRC];
  logic [NUM_SRC-1:0] src_used;
  logic [IDX_W-1:0] prod_rd  [NUM_PROD];
  prod_kind_t       prod_kind[NUM_PROD];
  logic [NUM_SRC-1:0] hit_mat [NUM_PROD];
  logic [NUM_PROD-1:0] prod_hit;
  logic ctl_reader;
  logic stall;

  // A direct jump reads no register even if a used bit leaks from decode.
  assign src_idx[0]  = id_rs1;
  assign src_idx[1]  = id_rs2;
  assign src_used    = {id_rs2_used, id_rs1_used} & {NUM_SRC{~id_is_jal}};

  assign prod_rd[PROD_EX]    = ex_rd;
  assign prod_rd[PROD_MEM]   = mem_rd;
  assign prod_kind[PROD_EX]  = '{wr: ex_reg_write,  ld: ex_mem_read};
  assign prod_kind[PROD_MEM] = '{wr: mem_reg_write, ld: mem_mem_read};

  assign ctl_reader = id_is_branch | id_is_jalr;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      hzd_src_match #(.IDX_W(IDX_W)) u_match (
        .src      (src_idx[s]),
        .src_used (src_used[s]),
        .dst      (prod_rd[p]),
        .dst_wr   (prod_kind[p].wr),
        .hit      (hit_mat[p][s])
      );
    end
    assign prod_hit[p] = |hit_mat[p];
  end

  hzd_cause u_cause (
    .hit_ex     (prod_hit[PROD_EX]),
    .hit_mem    (prod_hit[PROD_MEM]),
    .ex_ld      (prod_kind[PROD_EX].ld),
    .mem_ld     (prod_kind[PROD_MEM].ld),
    .ctl_reader (ctl_reader),
    .stall      (stall)
  );

  hzd_flush_ctl u_flush (
    .stall      (stall),
    .redirect   (id_redirect),
    .pc_hold    (pc_stall),
    .ifid_hold  (ifid_stall),
    .ifid_clear (ifid_flush),
    .idex_clear (idex_flush)
  );
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic [IDX_W-1:0] id_rs1,
  input logic [IDX_W-1:0] id_rs2,
  input logic             id_rs1_used,
  input logic             id_rs2_used,
  input logic             id_is_branch,
  input logic             id_is_jal,
  input logic             id_is_jalr,
  input logic             id_redirect,
  input logic [IDX_W-1:0] ex_rd,
  input logic             ex_reg_write,
  input logic             ex_mem_read,
  input logic [IDX_W-1:0] mem_rd,
  input logic             mem_reg_write,
  input logic             mem_mem_read,
  input logic             pc_stall,
  input logic             ifid_stall,
  input logic             ifid_flush,
  input logic             idex_flush
);
  logic known;
  logic ex_load_match;

  always_comb begin
    known = !$isunknown({id_rs1, id_rs2, id_rs1_used, id_rs2_used, id_is_branch,
                         id_is_jal, id_is_jalr, id_redirect, ex_rd, ex_reg_write,
                         ex_mem_read, mem_rd, mem_reg_write, mem_mem_read,
                         pc_stall, ifid_stall, ifid_flush, idex_flush});
    ex_load_match = ex_mem_read && ex_reg_write && (ex_rd != '0) && !id_is_jal &&
                    ((id_rs1_used && id_rs1 == ex_rd) || (id_rs2_used && id_rs2 == ex_rd));
    if (known) begin
      // R7
      hold_bubble_agree_chk: assert (pc_stall == ifid_stall && idex_flush == pc_stall)
        else $error("stall outputs disagree");
      // R9
      stall_beats_redirect_chk: assert (!(ifid_flush && pc_stall))
        else $error("flush asserted under stall");
      // R8
      redirect_flush_chk: assert ((id_redirect && !pc_stall) == ifid_flush)
        else $error("redirect flush wrong");
      // R1
      load_use_stall_chk: assert (!ex_load_match || pc_stall)
        else $error("load-use without stall");
      // R2
      zero_dest_chk: assert (!(ex_rd == '0 && mem_rd == '0) || !pc_stall)
        else $error("stall on register zero");
      // R6
      plain_no_stall_chk: assert (id_is_branch || id_is_jalr ||
                                  (ex_mem_read && ex_reg_write) || !pc_stall)
        else $error("plain instruction stalled without load in execute");
      // R5
      mem_load_ctl_chk: assert (!((id_is_branch || id_is_jalr) && !id_is_jal &&
                                  mem_mem_read && mem_reg_write && mem_rd != '0 &&
                                  ((id_rs1_used && id_rs1 == mem_rd) ||
                                   (id_rs2_used && id_rs2 == mem_rd))) || pc_stall)
        else $error("compare behind memory-stage load not stalled");
    end
  end
endmodule

bind hazard_unit hazard_unit_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb;
  localparam int unsigned W = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic id_rs1_used, id_rs2_used, id_is_branch, id_is_jal, id_is_jalr, id_redirect;
  logic ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read;
  logic pc_stall, ifid_stall, ifid_flush, idex_flush;

  int total = 0;
  int bad   = 0;

  hazard_unit #(.IDX_W(W)) u_dut (.*);

  // kind: 0 plain, 1 branch, 2 direct jump, 3 register jump
  task automatic drive(input logic [W-1:0] r1, input logic [W-1:0] r2,
                       input logic u1, input logic u2, input logic [1:0] kind,
                       input logic [W-1:0] erd, input logic erw, input logic emr,
                       input logic [W-1:0] mrd, input logic mrw, input logic mmr,
                       input logic redir);
    id_rs1 = r1; id_rs2 = r2; id_rs1_used = u1; id_rs2_used = u2;
    id_is_branch = (kind == 2'd1); id_is_jal = (kind == 2'd2); id_is_jalr = (kind == 2'd3);
    ex_rd = erd; ex_reg_write = erw; ex_mem_read = emr;
    mem_rd = mrd; mem_reg_write = mrw; mem_mem_read = mmr;
    id_redirect = redir;
  endtask

  // Output order {pc_stall, ifid_stall, ifid_flush, idex_flush}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    #1;
    act = {pc_stall, ifid_stall, ifid_flush, idex_flush};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
    #1;
  endtask

  function automatic logic [3:0] model(input logic [16:0] v);
    logic [W-1:0] r1, r2, erd, mrd;
    logic u1, u2, erw, emr, mrw, mmr, redir, ctl, hx, hm, stall;
    logic [1:0] kind;
    r1 = v[1:0]; r2 = v[3:2]; kind = v[7:6];
    u1 = v[4] && kind != 2'd2; u2 = v[5] && kind != 2'd2;
    erd = v[9:8]; erw = v[10]; emr = v[11];
    mrd = v[13:12]; mrw = v[14]; mmr = v[15]; redir = v[16];
    ctl = (kind == 2'd1) || (kind == 2'd3);
    hx = erw && erd != 0 && ((u1 && r1 == erd) || (u2 && r2 == erd));
    hm = mrw && mrd != 0 && ((u1 && r1 == mrd) || (u2 && r2 == mrd));
    stall = (hx && emr) || (ctl && hx && !emr) || (ctl && hm && mmr);
    return {stall, stall, redir && !stall, stall};
  endfunction

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(0,0,0,0,0, 0,0,0, 0,0,0, 0);
    #7;
    chk("R8 idle after start", 4'b0000);
    // R1 load in execute feeds a plain instruction
    drive(1,2,1,1,0, 1,1,1, 0,0,0, 0); chk("R1 load-use plain", 4'b1101);
    // R2 destination zero never a dependency
    drive(0,0,1,1,1, 0,1,1, 0,1,1, 0); chk("R2 zero dest", 4'b0000);
    // R3 unused source, non-writing producer, direct jump
    drive(3,1,0,0,0, 3,1,1, 0,0,0, 0); chk("R3 unused source", 4'b0000);
    drive(3,0,1,0,1, 3,0,1, 3,0,1, 0); chk("R3 no write flag", 4'b0000);
    drive(2,2,1,1,2, 2,1,1, 2,1,1, 1); chk("R3 direct jump", 4'b0010);
    // R4 branch on execute ALU result
    drive(0,3,0,1,1, 3,1,0, 0,0,0, 0); chk("R4 branch ex alu", 4'b1101);
    drive(2,0,1,0,3, 2,1,0, 0,0,0, 1); chk("R4 jalr ex alu", 4'b1101);
    // R5 load feeding a branch: first cycle in execute, second in memory
    drive(1,2,1,1,1, 2,1,1, 0,0,0, 0); chk("R5 load-branch cycle1", 4'b1101);
    @(posedge clk);
    drive(1,2,1,1,1, 0,0,0, 2,1,1, 0); chk("R5 load-branch cycle2", 4'b1101);
    @(posedge clk);
    drive(1,2,1,1,1, 0,0,0, 0,0,0, 1); chk("R5 load-branch resolved", 4'b0010);
    // R6 forwardable producers
    drive(1,1,1,1,1, 0,0,0, 1,1,0, 0); chk("R6 branch mem alu", 4'b0000);
    drive(1,1,1,1,0, 1,1,0, 1,1,1, 0); chk("R6 plain ex alu", 4'b0000);
    // R9 stall wins over redirect
    drive(1,0,1,0,3, 1,1,0, 0,0,0, 1); chk("R9 stall over redirect", 4'b1101);
    // R7 exhaustive sweep of the small configuration
    for (int v = 0; v < (1 << 17); v++) begin
      logic [16:0] b;
      logic [3:0] e;
      string tag;
      b = v[16:0];
      drive(b[1:0], b[3:2], b[4], b[5], b[7:6], b[9:8], b[10], b[11],
            b[13:12], b[14], b[15], b[16]);
      e = model(b);
      if (e[3] && b[11]) tag = "R1 sweep";
      else if (e[3] && !b[11]) tag = "R4/R5 sweep";
      else if (b[16]) tag = "R8 sweep";
      else tag = "R7 sweep";
      chk(tag, e);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule